// File: doc/BRIEF.md
# PWM Complementary Dead-Band Generator with Event Triggers

This block sits after a PWM time base and its action logic. It receives the raw PWM waveform and turns it into a pair of complementary outputs. When the raw waveform changes level, the output that is about to turn on is held low for a programmable number of time-base ticks. This keeps the two switches of a half bridge from ever conducting together. The low side is the exact inverse of the raw waveform; only its turn-on edge is delayed, in the same way as the high side.

The block also reads the status flags of the time-base counter: zero, period, compare match and count direction. From these it makes two independent single-cycle pulses. One pulse starts an ADC conversion and the other requests an interrupt. Each pulse has its own event select, so the two can follow different points of the PWM cycle. All timing is taken on a time-base tick input, which is a clock enable in the system clock domain.

Top module: `pwm_db_evt`

## Requirements
- R1: While `rst_n` is low, all four outputs are low.
- R2: With `db_len` = 0, the outputs are updated in the clock after each tick: `pwm_out_a` takes the raw input sampled at that tick and `pwm_out_b` takes its inverse.
- R3: After a raw edge at a tick, the output that the new level turns on rises at the tick `db_len` ticks later. Its register shows the change one clock after that tick.
- R4: `pwm_out_a` and `pwm_out_b` are never high together. Both stay low for `db_len` ticks after each raw edge.
- R5: `soc_sel` codes: 0 = off, 1 = counter zero, 2 = counter period, 3 = zero or period, 4 = compare match while counting up (`ctr_up` = 1), 5 = compare match while counting down (`ctr_up` = 0). Codes 6 and 7 act as off.
- R6: `int_sel` uses the same codes as R5. It drives `int_req` independently of `soc_sel`.
- R7: If the raw level lasts fewer ticks than `db_len`, the output it would turn on stays low for that whole pulse.
- R8: The compare choices fire only when the compare flag is set and the direction flag matches the selected direction.
- R9: An event output pulses high for exactly one clock, in the clock after the first tick at which its condition is true. It does not pulse again until the condition has been false at some tick.
- R10: The outputs change only in the clock that follows a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Time-base clock enable |
| pwm_a_raw | input | 1 | Raw PWM waveform from the action logic |
| ctr_is_zero | input | 1 | Time-base counter equals zero |
| ctr_is_prd | input | 1 | Time-base counter equals period |
| ctr_is_cmp | input | 1 | Time-base counter equals compare value |
| ctr_up | input | 1 | Counter is incrementing (1) or decrementing (0) |
| db_len | input | 16 | Dead-band length in ticks |
| soc_sel | input | 3 | ADC trigger event select (R5 codes) |
| int_sel | input | 3 | Interrupt event select (R5 codes) |
| pwm_out_a | output | 1 | High-side output with dead band |
| pwm_out_b | output | 1 | Low-side output with dead band |
| adc_soc | output | 1 | ADC start-of-conversion pulse |
| int_req | output | 1 | Interrupt request pulse |

## Verification
The ADC trigger and the interrupt request can pulse in the same clock. This happens when both selects name the same event, or when they name overlapping events, for example zero on one and zero-or-period on the other. The bench sets up such select pairs on an up-down count and checks both pulses in the same cycle against its own model. A dead-band reload can also land on the same tick as an event pulse, since a raw edge at compare coincides with a compare event. The bench checks every cycle that each path gives its expected value at that tick.

// File: rtl/pwm_dbe_pkg.sv
package pwm_dbe_pkg;

    typedef enum logic [2:0] {
        EV_OFF    = 3'd0,
        EV_ZERO   = 3'd1,
        EV_PRD    = 3'd2,
        EV_ZP     = 3'd3,
        EV_CMP_UP = 3'd4,
        EV_CMP_DN = 3'd5
    } ev_sel_e;

    typedef struct packed {
        logic zero;
        logic prd;
        logic cmp;
        logic up;
    } ctr_stat_t;

    function automatic logic ev_hit(input logic [2:0] sel, input ctr_stat_t st);
        logic hit;
        case (sel)
            EV_ZERO:   hit = st.zero;
            EV_PRD:    hit = st.prd;
            EV_ZP:     hit = st.zero | st.prd;
            EV_CMP_UP: hit = st.cmp & st.up;
            EV_CMP_DN: hit = st.cmp & ~st.up;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pwm_evt_decode.sv
module pwm_evt_decode
    import pwm_dbe_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctr_stat_t        stat,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);

    typedef struct packed {
        logic seen;
        logic pulse;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit = ev_hit(sel[2:0], stat);
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (tick) begin
            st_d.pulse = hit & ~st_q.seen;
            st_d.seen  = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

endmodule

// File: rtl/pwm_db_timer.sv
module pwm_db_timer #(
    parameter int DB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            a_in,
    input  logic [DB_W-1:0] db_len,
    output logic            expired_d
);

    typedef struct packed {
        logic            a_prev;
        logic [DB_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    edge_seen;

    always_comb begin
        st_d = st_q;
        edge_seen = tick && (a_in != st_q.a_prev);
        if (tick) begin
            st_d.a_prev = a_in;
            if (edge_seen) begin
                st_d.cnt = db_len;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        expired_d = (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_db_gate.sv
module pwm_db_gate #(
    parameter bit ON_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic a_in,
    input  logic expired,
    output logic out
);

    logic out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (tick) begin
            out_d = (a_in == ON_LEVEL) && expired;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out = out_q;

endmodule

// File: rtl/pwm_db_evt.sv
module pwm_db_evt
    import pwm_dbe_pkg::*;
#(
    parameter int DB_W  = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  logic             pwm_a_raw,
    input  logic             ctr_is_zero,
    input  logic             ctr_is_prd,
    input  logic             ctr_is_cmp,
    input  logic             ctr_up,
    input  logic [DB_W-1:0]  db_len,
    input  logic [SEL_W-1:0] soc_sel,
    input  logic [SEL_W-1:0] int_sel,
    output logic             pwm_out_a,
    output logic             pwm_out_b,
    output logic             adc_soc,
    output logic             int_req
);

    localparam int N_OUT = 2;
    localparam int N_EVT = 2;

    ctr_stat_t        stat;
    logic             expired;
    logic [N_OUT-1:0] outs;
    logic [N_EVT-1:0] pulses;
    logic [SEL_W-1:0] sels [N_EVT];

    always_comb begin
        stat.zero = ctr_is_zero;
        stat.prd  = ctr_is_prd;
        stat.cmp  = ctr_is_cmp;
        stat.up   = ctr_up;
        sels[0]   = soc_sel;
        sels[1]   = int_sel;
    end

    pwm_db_timer #(.DB_W(DB_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tb_tick),
        .a_in      (pwm_a_raw),
        .db_len    (db_len),
        .expired_d (expired)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        pwm_db_gate #(.ON_LEVEL(g == 0)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tb_tick),
            .a_in    (pwm_a_raw),
            .expired (expired),
            .out     (outs[g])
        );
    end

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        pwm_evt_decode #(.SEL_W(SEL_W)) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tb_tick),
            .stat  (stat),
            .sel   (sels[e]),
            .pulse (pulses[e])
        );
    end

    assign pwm_out_a = outs[0];
    assign pwm_out_b = outs[1];
    assign adc_soc   = pulses[0];
    assign int_req   = pulses[1];

endmodule

// File: rtl/pwm_db_evt_chk.sv
module pwm_db_evt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tb_tick,
    input logic       pwm_a_raw,
    input logic       ctr_is_cmp,
    input logic       ctr_up,
    input logic [2:0] soc_sel,
    input logic [2:0] int_sel,
    input logic       pwm_out_a,
    input logic       pwm_out_b,
    input logic       adc_soc,
    input logic       int_req
);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_out_a && pwm_out_b));

    assert_rise_from_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out_a) |-> ($past(pwm_a_raw) && $past(tb_tick)));

    assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tb_tick) |-> ($stable(pwm_out_a) && $stable(pwm_out_b)));

    assert_soc_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_soc |=> !adc_soc);

    assert_int_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> !int_req);

    assert_soc_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(soc_sel) == 3'd0) |-> !adc_soc);

    assert_int_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && $past(int_sel) == 3'd4) |-> ($past(ctr_is_cmp) && $past(ctr_up)));

endmodule

bind pwm_db_evt pwm_db_evt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_tick    (tb_tick),
    .pwm_a_raw  (pwm_a_raw),
    .ctr_is_cmp (ctr_is_cmp),
    .ctr_up     (ctr_up),
    .soc_sel    (soc_sel),
    .int_sel    (int_sel),
    .pwm_out_a  (pwm_out_a),
    .pwm_out_b  (pwm_out_b),
    .adc_soc    (adc_soc),
    .int_req    (int_req)
);

// File: tb/tb_pwm_db_evt.sv
module tb_pwm_db_evt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic        pwm_a_raw = 1'b0;
    logic        ctr_is_zero = 1'b0;
    logic        ctr_is_prd = 1'b0;
    logic        ctr_is_cmp = 1'b0;
    logic        ctr_up = 1'b0;
    logic [15:0] db_len = '0;
    logic [2:0]  soc_sel = '0;
    logic [2:0]  int_sel = '0;
    logic        pwm_out_a, pwm_out_b, adc_soc, int_req;

    always #5 clk = ~clk;

    pwm_db_evt dut (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .pwm_a_raw(pwm_a_raw),
        .ctr_is_zero(ctr_is_zero), .ctr_is_prd(ctr_is_prd), .ctr_is_cmp(ctr_is_cmp),
        .ctr_up(ctr_up), .db_len(db_len), .soc_sel(soc_sel), .int_sel(int_sel),
        .pwm_out_a(pwm_out_a), .pwm_out_b(pwm_out_b), .adc_soc(adc_soc), .int_req(int_req)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 0;

    // time-base stimulus state
    int prd_v = 20, cmp_v = 8, div_v = 2, div_cnt = 0, tbc = 0;
    bit dir_up = 1;

    // reference model state
    int m_prev = 0, m_cnt = 0;
    bit m_oa = 0, m_ob = 0, m_adc = 0, m_irq = 0, m_as = 0, m_is = 0;

    function automatic bit ev_ref(input int code);
        case (code)
            1: return ctr_is_zero;
            2: return ctr_is_prd;
            3: return ctr_is_zero || ctr_is_prd;
            4: return ctr_is_cmp && ctr_up;
            5: return ctr_is_cmp && !ctr_up;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_cnt = 0; m_oa = 0; m_ob = 0;
            m_adc = 0; m_irq = 0; m_as = 0; m_is = 0;
        end else begin
            m_adc = 0;
            m_irq = 0;
            if (tb_tick) begin
                if (ev_ref(int'(soc_sel)) && !m_as) m_adc = 1;
                m_as = ev_ref(int'(soc_sel));
                if (ev_ref(int'(int_sel)) && !m_is) m_irq = 1;
                m_is = ev_ref(int'(int_sel));
                if (int'(pwm_a_raw) != m_prev) m_cnt = int'(db_len);
                else if (m_cnt > 0) m_cnt = m_cnt - 1;
                m_prev = int'(pwm_a_raw);
                m_oa = pwm_a_raw && (m_cnt == 0);
                m_ob = !pwm_a_raw && (m_cnt == 0);
            end
        end
    end

    task automatic check1(input string req, input string nm, input bit act, input bit exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check1(tag, "pwm_out_a", pwm_out_a, m_oa);
            check1(tag, "pwm_out_b", pwm_out_b, m_ob);
            check1(tag == "R6" ? "R6" : "R5", "adc_soc", adc_soc, m_adc);
            check1(tag == "R5" ? "R5" : "R6", "int_req", int_req, m_irq);
            check1("R4", "both_high", pwm_out_a && pwm_out_b, 1'b0);
            if (rst_n) begin
                tb_tick = (div_cnt == 0);
                div_cnt = (div_cnt + 1) % div_v;
                ctr_is_zero = (tbc == 0);
                ctr_is_prd = (tbc == prd_v);
                ctr_is_cmp = (tbc == cmp_v);
                ctr_up = dir_up;
                pwm_a_raw = (tbc >= cmp_v);
                if (tb_tick) begin
                    if (dir_up) begin
                        tbc++;
                        if (tbc >= prd_v) begin tbc = prd_v; dir_up = 0; end
                    end else begin
                        tbc--;
                        if (tbc <= 0) begin tbc = 0; dir_up = 1; end
                    end
                end
            end
        end
    end

    task automatic phase(input string t, input int db, input int s, input int i,
                         input int p, input int c, input int d, input int cycles);
        @(negedge clk);
        tag = t;
        db_len = 16'(db);
        soc_sel = 3'(s);
        int_sel = 3'(i);
        prd_v = p;
        cmp_v = c;
        div_v = d;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        phase("R2", 0, 1, 0, 20, 8, 2, 300);   // complement with no dead band
        phase("R3", 3, 2, 3, 20, 8, 2, 400);   // delayed turn-on
        phase("R4", 6, 3, 7, 16, 5, 1, 300);   // both-low window, code 7 is off
        phase("R7", 5, 0, 1, 20, 19, 2, 400);  // raw high for 3 ticks < 5
        phase("R8", 2, 4, 5, 20, 8, 2, 400);   // direction-qualified compare
        phase("R6", 1, 0, 2, 12, 4, 3, 300);   // interrupt only, on period
        phase("R9", 4, 1, 3, 12, 6, 3, 400);   // simultaneous pulses
        phase("R10", 65535, 6, 1, 10, 3, 4, 300); // long band, slow ticks
        phase("R5", 0, 5, 0, 20, 8, 1, 200);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule